// File: doc/BRIEF.md
# Periodic Frame List Address Generator

This block runs the microframe counter of a high-speed USB host and turns it into the system-memory address of the periodic frame list slot that the schedule should use now. A counter of microframes advances on each end-of-microframe strobe while the controller runs. Its top eleven bits form the frame number carried in the start-of-frame token. A slice of it selects one 4-byte slot in a list whose length, 1024, 512 or 256 slots, is chosen by a 2-bit size field that software can change at run time. The slot address joins a 4 kB aligned base with the slot offset. When the host supports 64-bit addressing, it also takes an upper 32-bit segment.

Software reaches four fields through a plain register port with one select. Writes take effect on the clock edge and reads are combinational. The frame index, base, segment and size field each have their own select. The port has no data stream and no back-pressure: a write strobe is accepted in the cycle it is high, and the read data follows the select in the same cycle. The strobes and enables are plain level pins.

Top module: `flist_addr_gen`

## Requirements
- R1: After reset the frame index, base, segment and size field are zero, every register read returns zero, and `entry_addr`, `sof_frame` and `size_err` are zero.
- R2: The frame index increments by one on each clock edge where `run_en` and `uframe_end` are both high. In every other cycle without a write it holds its value.
- R3: The frame index wraps from 0x3FFF to 0x0000.
- R4: A write with `reg_sel`=0 loads `reg_wdata[13:0]` into the frame index and takes priority over an increment in the same cycle. A read with select 0 returns the index in bits 13:0, with bits 31:14 zero.
- R5: `sof_frame` equals bits 13:3 of the frame index, so it changes once every eight increments.
- R6: `entry_addr[31:0]` is base bits 31:12, then frame index bits N:3 at address bits N-1:2 with zeros above them up to bit 11, then two zero bits. N is 12, 11 or 10 for size codes 00, 01 and 10. The size field is written and read through select 3, in bits 1:0, and its other read bits are zero.
- R7: The base is written and read through select 1. Bits 11:0 of the written value are dropped and read back as zero.
- R8: While `cap_64` is high, the segment (select 2) is writable and readable, and `entry_addr[63:32]` equals it.
- R9: While `cap_64` is low, segment writes are ignored, segment reads return zero, and `entry_addr[63:32]` is zero. A value stored earlier reappears once `cap_64` is high again.
- R10: Size code 11 addresses the list as 1024 slots (N=12), and `size_err` is high exactly while that code is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Controller running; enables counting |
| uframe_end | input | 1 | End-of-microframe strobe |
| cap_64 | input | 1 | 64-bit addressing capability present |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Field select: 0 index, 1 base, 2 segment, 3 size |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected field |
| sof_frame | output | 11 | Frame number for the start-of-frame token |
| entry_addr | output | 64 | Address of the current frame list slot |
| size_err | output | 1 | Reserved size code selected |

## Verification
The properties assume that `reg_sel` and `reg_wdata` are stable and known whenever `reg_wr` is high, and that `run_en` and `uframe_end` change only away from the clock edge. The bench drives every input on the falling edge and holds it through the next rising edge, so each property sees one clean value per cycle. The properties also assume that `cap_64` does not change in the same cycle as a segment write. The bench changes `cap_64` only in cycles with no write.

// File: rtl/flist_pkg.sv
package flist_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX   = 2'd0,
    SEL_BASE    = 2'd1,
    SEL_SEGMENT = 2'd2,
    SEL_SIZE    = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    LEN_1024 = 2'b00,
    LEN_512  = 2'b01,
    LEN_256  = 2'b10,
    LEN_RSVD = 2'b11
  } list_len_e;
endpackage

// File: rtl/fl_index_ctr.sv
module fl_index_ctr #(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  // A software load wins over a step; the sum wraps at 2**IDX_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= load_val;
    else if (step) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/fl_cfg_regs.sv
module fl_cfg_regs #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_64,
  input  logic                      wr_base,
  input  logic                      wr_seg,
  input  logic                      wr_size,
  input  logic [ADDR_W-1:0]         wdata,
  output logic [ADDR_W-1:PAGE_LSB]  base,
  output logic [ADDR_W-1:0]         seg,
  output logic [1:0]                size
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      seg  <= '0;
      size <= '0;
    end else begin
      if (wr_base)          base <= wdata[ADDR_W-1:PAGE_LSB];
      if (wr_seg && cap_64) seg  <= wdata;
      if (wr_size)          size <= wdata[1:0];
    end
  end
endmodule

// File: rtl/fl_addr_form.sv
module fl_addr_form
  import flist_pkg::*;
#(
  parameter int IDX_W    = 14,
  parameter int SUB_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [1:0]               size,
  input  logic [ADDR_W-1:PAGE_LSB] base,
  input  logic [ADDR_W-1:0]        seg,
  input  logic                     cap_64,
  output logic [2*ADDR_W-1:0]      entry_addr,
  output logic [IDX_W-SUB_W-1:0]   sof_frame,
  output logic                     size_err
);
  // Slots are 4 bytes, so a page holds 2**SLOT_W slots.
  localparam int SLOT_W = PAGE_LSB - 2;

  logic [SLOT_W-1:0] slot_raw;
  logic [SLOT_W-1:0] slot_mask;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        shrink;

  assign slot_raw  = idx[SUB_W +: SLOT_W];
  assign sof_frame = idx[IDX_W-1:SUB_W];

  always_comb begin
    unique case (list_len_e'(size))
      LEN_512: shrink = 2'd1;
      LEN_256: shrink = 2'd2;
      default: shrink = 2'd0;
    endcase
  end

  assign slot_mask = {SLOT_W{1'b1}} >> shrink;

  for (genvar b = 0; b < SLOT_W; b++) begin : g_slot
    assign slot[b] = slot_raw[b] & slot_mask[b];
  end

  assign entry_addr[ADDR_W-1:0]        = {base, slot, 2'b00};
  assign entry_addr[2*ADDR_W-1:ADDR_W] = cap_64 ? seg : '0;
  assign size_err = (list_len_e'(size) == LEN_RSVD);
endmodule

// File: rtl/flist_addr_gen.sv
module flist_addr_gen
  import flist_pkg::*;
#(
  parameter int IDX_W    = 14,
  parameter int SUB_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic                     uframe_end,
  input  logic                     cap_64,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_sel,
  input  logic [ADDR_W-1:0]        reg_wdata,
  output logic [ADDR_W-1:0]        reg_rdata,
  output logic [IDX_W-SUB_W-1:0]   sof_frame,
  output logic [2*ADDR_W-1:0]      entry_addr,
  output logic                     size_err
);
  logic [IDX_W-1:0]         idx_q;
  logic [ADDR_W-1:PAGE_LSB] base_q;
  logic [ADDR_W-1:0]        seg_q;
  logic [1:0]               size_q;
  logic                     wr_idx, wr_base, wr_seg, wr_size, step;

  assign wr_idx  = reg_wr && (reg_sel_e'(reg_sel) == SEL_INDEX);
  assign wr_base = reg_wr && (reg_sel_e'(reg_sel) == SEL_BASE);
  assign wr_seg  = reg_wr && (reg_sel_e'(reg_sel) == SEL_SEGMENT);
  assign wr_size = reg_wr && (reg_sel_e'(reg_sel) == SEL_SIZE);
  assign step    = run_en && uframe_end;

  fl_index_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(wr_idx),
    .load_val(reg_wdata[IDX_W-1:0]), .step(step), .idx(idx_q)
  );

  fl_cfg_regs #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cap_64(cap_64),
    .wr_base(wr_base), .wr_seg(wr_seg), .wr_size(wr_size),
    .wdata(reg_wdata), .base(base_q), .seg(seg_q), .size(size_q)
  );

  fl_addr_form #(.IDX_W(IDX_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W),
                 .PAGE_LSB(PAGE_LSB)) u_addr (
    .idx(idx_q), .size(size_q), .base(base_q), .seg(seg_q),
    .cap_64(cap_64), .entry_addr(entry_addr), .sof_frame(sof_frame),
    .size_err(size_err)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_sel))
      SEL_INDEX:   reg_rdata[IDX_W-1:0]         = idx_q;
      SEL_BASE:    reg_rdata[ADDR_W-1:PAGE_LSB] = base_q;
      SEL_SEGMENT: reg_rdata                    = cap_64 ? seg_q : '0;
      SEL_SIZE:    reg_rdata[1:0]               = size_q;
      default:     reg_rdata                    = '0;
    endcase
  end
endmodule

// File: rtl/flist_addr_gen_chk.sv
module flist_addr_gen_chk #(
  parameter int IDX_W    = 14,
  parameter int SUB_W    = 3,
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   step,
  input logic                   wr_idx,
  input logic                   wr_base,
  input logic                   cap_64,
  input logic [ADDR_W-1:0]      reg_wdata,
  input logic [IDX_W-1:0]       idx_q,
  input logic [IDX_W-SUB_W-1:0] sof_frame,
  input logic [2*ADDR_W-1:0]    entry_addr
);
  // R2 R3
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_idx) |=> (idx_q == $past(idx_q) + 1'b1));

  // R2
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_idx) |=> $stable(idx_q));

  // R5
  sof_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_idx && (idx_q[SUB_W-1:0] != {SUB_W{1'b1}})) |=> $stable(sof_frame));

  // R7
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> (entry_addr[ADDR_W-1:PAGE_LSB] == $past(reg_wdata[ADDR_W-1:PAGE_LSB])));

  // R9
  seg_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_64 |-> (entry_addr[2*ADDR_W-1:ADDR_W] == '0));
endmodule

bind flist_addr_gen flist_addr_gen_chk #(
  .IDX_W(IDX_W), .SUB_W(SUB_W), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .wr_idx(wr_idx), .wr_base(wr_base),
  .cap_64(cap_64), .reg_wdata(reg_wdata), .idx_q(idx_q),
  .sof_frame(sof_frame), .entry_addr(entry_addr)
);

// File: tb/flist_addr_gen_test.sv
module flist_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, run_en, uframe_end, cap_64, reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [10:0] sof_frame;
  logic [63:0] entry_addr;
  logic        size_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flist_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .uframe_end(uframe_end),
    .cap_64(cap_64), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sof_frame(sof_frame), .entry_addr(entry_addr),
    .size_err(size_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(input logic [13:0] idx, input logic [1:0] sz,
                                           input logic [31:0] base, input logic [31:0] seg,
                                           input logic cap);
    int n;
    logic [31:0] slot;
    n = (sz == 2'b01) ? 11 : (sz == 2'b10) ? 10 : 12;
    slot = (32'(idx) >> 3) & ((32'd1 << (n - 2)) - 1);
    return {cap ? seg : 32'h0, (base & 32'hFFFF_F000) | (slot << 2)};
  endfunction

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    cycle();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      uframe_end = 1'b1; cycle(); uframe_end = 1'b0; cycle();
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0; run_en = 0; uframe_end = 0; cap_64 = 1; reg_wr = 0;
    reg_sel = 0; reg_wdata = '0;
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 read", 64'(d), 64'h0);
    end
    chk("R1 entry_addr", entry_addr, 64'h0);
    chk("R1 sof_frame", 64'(sof_frame), 64'h0);
    chk("R1 size_err", 64'(size_err), 64'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    run_en = 1'b1;
    pulses(5);
    rd(0, d); chk("R2 five steps", 64'(d), 64'd5);
    run_en = 1'b0;
    pulses(3);
    rd(0, d); chk("R2 hold when stopped", 64'(d), 64'd5);
    run_en = 1'b1;
    repeat (4) cycle();
    rd(0, d); chk("R2 hold without strobe", 64'(d), 64'd5);
    chk("R5 sof before eight", 64'(sof_frame), 64'd0);
    uframe_end = 1'b1; repeat (3) cycle(); uframe_end = 1'b0;
    rd(0, d); chk("R2 held strobe", 64'(d), 64'd8);
    chk("R5 sof after eight", 64'(sof_frame), 64'd1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(0, 32'h0000_3FFF);
    chk("R5 sof at top", 64'(sof_frame), 64'h7FF);
    pulses(1);
    rd(0, d); chk("R3 wrap", 64'(d), 64'h0);
    chk("R3 sof wrap", 64'(sof_frame), 64'h0);
  endtask

  task automatic t_write_prio();
    logic [31:0] d;
    run_en = 1'b1; uframe_end = 1'b1;
    wr(0, 32'hFFFF_ABCD);
    uframe_end = 1'b0;
    rd(0, d); chk("R4 load beats step, reserved zero", 64'(d), 64'h2BCD);
    chk("R5 sof of loaded", 64'(sof_frame), 64'(14'h2BCD >> 3));
    run_en = 1'b0;
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(1, 32'h1234_5FFF);
    rd(1, d); chk("R7 base low bits dropped", 64'(d), 64'h1234_5000);
    wr(0, 32'h0000_3FF8);
    for (int s = 0; s < 4; s++) begin
      wr(3, 32'hFFFF_FFF0 | 32'(s));
      rd(3, d); chk("R6 size readback", 64'(d), 64'(s));
      chk(s == 3 ? "R10 reserved size addr" : "R6 entry addr", entry_addr,
          exp_addr(14'h3FF8, 2'(s), 32'h1234_5FFF, 32'h0, 1'b1));
      chk(s == 3 ? "R10 size_err set" : "R10 size_err clear", 64'(size_err),
          64'(s == 3));
    end
    wr(3, 32'h1);
    wr(0, 32'h0000_0A50);
    chk("R6 512 slots", entry_addr, exp_addr(14'h0A50, 2'b01, 32'h1234_5000, 32'h0, 1'b1));
    wr(3, 32'h0);
  endtask

  task automatic t_seg();
    logic [31:0] d;
    cap_64 = 1'b1;
    wr(2, 32'hCAFE_F00D);
    rd(2, d); chk("R8 seg read", 64'(d), 64'hCAFE_F00D);
    chk("R8 upper addr", 64'(entry_addr[63:32]), 64'hCAFE_F00D);
    cap_64 = 1'b0; cycle();
    rd(2, d); chk("R9 seg read hidden", 64'(d), 64'h0);
    chk("R9 upper addr zero", 64'(entry_addr[63:32]), 64'h0);
    wr(2, 32'h1111_1111);
    cap_64 = 1'b1; cycle();
    rd(2, d); chk("R9 write ignored", 64'(d), 64'hCAFE_F00D);
  endtask

  initial begin
    t_reset();
    t_count();
    t_wrap();
    t_write_prio();
    t_addr();
    t_seg();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule